// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block keeps one 64-bit stack pointer for each of four privilege levels (level 0 up to level 3), together with a single selection bit. From these it works out which pointer is live for the level the core is running at. When the selection bit is clear, every level shares the level-0 pointer. When it is set, each level uses its own pointer. Reads of the live pointer are combinational. A write lands only in the pointer that is live at the moment of the write.

The same selection bit also decides the exception vector group. An exception that stays at the same level reports group 0 while the shared pointer is selected and group 1 while the level's own pointer is selected. An exception that comes up from a lower level always reports group 2.

Exception entry saves the current selection bit into a saved-state bit kept for the target level, then forces the selection bit to 1. Exception return copies the saved bit of the current level back into the selection bit. The current level itself is an input: the block never changes it.

Top module: `banked_sp_sel`

## Requirements
- R1: Four 64-bit pointers are held, one per level. Each keeps its value until a write is directed at it.
- R2: The selection readback is 64 bits wide and the selection is bit 0. Bits 63:1 always read zero, and whatever is written to them is discarded.
- R3: While the selection bit is 0, the live pointer at every level is the level-0 pointer.
- R4: While the selection bit is 1, the live pointer is the one belonging to the current level.
- R5: At level 0 the live pointer is the level-0 pointer, whatever the selection bit holds.
- R6: Synchronous active-high reset sets the selection bit to 1, every saved-state bit to 1 and all four pointers to zero.
- R7: The vector group output is combinational. When source level equals target level it is 0 with the selection bit clear and 1 with the selection bit set.
- R8: When source level differs from target level, the vector group is 2, whatever the selection bit holds.
- R9: An entry strobe stores the selection bit into the saved bit of the target level. The selection bit then reads 1 from the next cycle on.
- R10: A return strobe (with no entry strobe in the same cycle) loads the selection bit, on the next cycle, from the saved bit of the current level.
- R11: A pointer write updates only the pointer that is live in the cycle of the write, as seen from the next cycle. All other pointers are unchanged.
- R12: A selection write takes effect on the next cycle at levels 1 to 3 and is ignored at level 0. In the same cycle, an entry strobe overrides a return strobe, and a return strobe overrides a selection write.
- R13: The live pointer readback follows a change of current level or selection bit in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cur_lvl | input | 2 | Current privilege level |
| sel_wr_en | input | 1 | Selection register write strobe |
| sel_wr_data | input | 64 | Selection write data; only bit 0 is kept |
| sel_rd | output | 64 | Selection register readback |
| sp_wr_en | input | 1 | Live pointer write strobe |
| sp_wr_data | input | 64 | Live pointer write data |
| sp_rd | output | 64 | Live pointer value |
| exc_take | input | 1 | Exception entry strobe |
| exc_src_lvl | input | 2 | Level the exception is taken from |
| exc_dst_lvl | input | 2 | Level the exception is taken to |
| exc_ret | input | 1 | Exception return strobe |
| vec_grp | output | 2 | Vector group: 0 same level shared pointer, 1 same level own pointer, 2 from lower level |

## Verification
The assertions assume that the source level of an exception is never above its target level. They also assume that the current level does not change in the same cycle as a pointer write whose result is being checked. The stimulus only issues entries from a level to itself or upward. It changes the current level only in cycles that carry no pointer write. Return strobes are issued at the level that was entered, so the saved bit being restored is one the bench has itself recorded.

// File: rtl/spsel_pkg.sv
package spsel_pkg;

    localparam int XLEN    = 64;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [XLEN-1:0]  word_t;

    typedef enum logic [1:0] {
        VG_SAME_SHARED = 2'd0,
        VG_SAME_OWN    = 2'd1,
        VG_FROM_LOWER  = 2'd2,
        VG_UNUSED      = 2'd3
    } vgrp_e;

    typedef struct packed {
        logic take;
        lvl_t src;
        lvl_t dst;
        logic ret;
    } exc_evt_t;

    // Bank index that is live for a level under a given selection bit.
    function automatic lvl_t live_bank(input logic sel, input lvl_t lvl);
        return sel ? lvl : '0;
    endfunction

endpackage

// File: rtl/spsel_ctrl.sv
module spsel_ctrl
    import spsel_pkg::*;
#(
    parameter int NLVL = NUM_LVL
) (
    input  logic     clk,
    input  logic     rst,
    input  lvl_t     cur_lvl,
    input  logic     wr_en,
    input  logic     wr_bit,
    input  exc_evt_t evt,
    output logic     sel_q
);

    logic [NLVL-1:0] saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b1;
            saved_q <= '1;
        end else if (evt.take) begin
            saved_q[evt.dst] <= sel_q;
            sel_q            <= 1'b1;
        end else if (evt.ret) begin
            sel_q <= saved_q[cur_lvl];
        end else if (wr_en && (cur_lvl != '0)) begin
            sel_q <= wr_bit;
        end
    end

endmodule

// File: rtl/sp_bank.sv
module sp_bank
    import spsel_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NLVL = NUM_LVL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  lvl_t         wr_idx,
    input  logic [W-1:0] wr_data,
    input  lvl_t         rd_idx,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] bank_q [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '0;
            end else if (wr_en && (wr_idx == lvl_t'(g))) begin
                bank_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = bank_q[rd_idx];

endmodule

// File: rtl/vec_group.sv
module vec_group
    import spsel_pkg::*;
(
    input  lvl_t  src_lvl,
    input  lvl_t  dst_lvl,
    input  logic  sel,
    output vgrp_e grp
);

    always_comb begin
        if (src_lvl == dst_lvl) begin
            grp = sel ? VG_SAME_OWN : VG_SAME_SHARED;
        end else begin
            grp = VG_FROM_LOWER;
        end
    end

endmodule

// File: rtl/banked_sp_sel.sv
module banked_sp_sel
    import spsel_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NLVL = NUM_LVL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   cur_lvl,
    input  logic         sel_wr_en,
    input  logic [W-1:0] sel_wr_data,
    output logic [W-1:0] sel_rd,
    input  logic         sp_wr_en,
    input  logic [W-1:0] sp_wr_data,
    output logic [W-1:0] sp_rd,
    input  logic         exc_take,
    input  logic [1:0]   exc_src_lvl,
    input  logic [1:0]   exc_dst_lvl,
    input  logic         exc_ret,
    output logic [1:0]   vec_grp
);

    exc_evt_t evt;
    logic     sel_q;
    lvl_t     live_idx;
    vgrp_e    grp;
    logic     unused_wr_hi;

    assign evt          = '{take: exc_take, src: exc_src_lvl, dst: exc_dst_lvl, ret: exc_ret};
    assign unused_wr_hi = ^sel_wr_data[W-1:1];

    spsel_ctrl #(.NLVL(NLVL)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cur_lvl (cur_lvl),
        .wr_en   (sel_wr_en),
        .wr_bit  (sel_wr_data[0]),
        .evt     (evt),
        .sel_q   (sel_q)
    );

    assign live_idx = live_bank(sel_q, cur_lvl);

    sp_bank #(.W(W), .NLVL(NLVL)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sp_wr_en),
        .wr_idx  (live_idx),
        .wr_data (sp_wr_data),
        .rd_idx  (live_idx),
        .rd_data (sp_rd)
    );

    vec_group u_vec (
        .src_lvl (evt.src),
        .dst_lvl (evt.dst),
        .sel     (sel_q),
        .grp     (grp)
    );

    assign vec_grp = grp;
    assign sel_rd  = {{(W-1){1'b0}}, sel_q};

endmodule

// File: rtl/spsel_chk.sv
module spsel_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   cur_lvl,
    input logic         sel_wr_en,
    input logic [W-1:0] sel_rd,
    input logic         sp_wr_en,
    input logic [W-1:0] sp_wr_data,
    input logic [W-1:0] sp_rd,
    input logic         exc_take,
    input logic [1:0]   exc_src_lvl,
    input logic [1:0]   exc_dst_lvl,
    input logic         exc_ret,
    input logic [1:0]   vec_grp
);

    assert_resv_zero_R2: assert property (@(posedge clk) disable iff (rst)
        sel_rd[W-1:1] == '0);

    assert_same_lvl_grp_R7: assert property (@(posedge clk) disable iff (rst)
        (exc_take && exc_src_lvl == exc_dst_lvl) |-> (vec_grp == {1'b0, sel_rd[0]}));

    assert_lower_grp_R8: assert property (@(posedge clk) disable iff (rst)
        (exc_take && exc_src_lvl != exc_dst_lvl) |-> (vec_grp == 2'd2));

    assert_entry_sets_R9: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> sel_rd[0]);

    assert_sp_write_R11: assert property (@(posedge clk) disable iff (rst)
        (sp_wr_en && !exc_take && !exc_ret && !sel_wr_en)
        |=> ($stable(cur_lvl) -> (sp_rd == $past(sp_wr_data))));

    assert_el0_sel_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (sel_wr_en && cur_lvl == 2'd0 && !exc_take && !exc_ret) |=> $stable(sel_rd));

endmodule

bind banked_sp_sel spsel_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cur_lvl     (cur_lvl),
    .sel_wr_en   (sel_wr_en),
    .sel_rd      (sel_rd),
    .sp_wr_en    (sp_wr_en),
    .sp_wr_data  (sp_wr_data),
    .sp_rd       (sp_rd),
    .exc_take    (exc_take),
    .exc_src_lvl (exc_src_lvl),
    .exc_dst_lvl (exc_dst_lvl),
    .exc_ret     (exc_ret),
    .vec_grp     (vec_grp)
);

// File: tb/tb_banked_sp_sel.sv
module tb_banked_sp_sel;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cur_lvl = '0;
    logic        sel_wr_en = 1'b0;
    logic [63:0] sel_wr_data = '0;
    logic [63:0] sel_rd;
    logic        sp_wr_en = 1'b0;
    logic [63:0] sp_wr_data = '0;
    logic [63:0] sp_rd;
    logic        exc_take = 1'b0;
    logic [1:0]  exc_src_lvl = '0;
    logic [1:0]  exc_dst_lvl = '0;
    logic        exc_ret = 1'b0;
    logic [1:0]  vec_grp;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [63:0] m_sp [4];
    logic        m_sel;
    logic [3:0]  m_sav;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_sp_sel dut (
        .clk(clk), .rst(rst), .cur_lvl(cur_lvl),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data), .sel_rd(sel_rd),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_rd(sp_rd),
        .exc_take(exc_take), .exc_src_lvl(exc_src_lvl), .exc_dst_lvl(exc_dst_lvl),
        .exc_ret(exc_ret), .vec_grp(vec_grp)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; reference model follows the requirements.
    task automatic step();
        logic [1:0] idx;
        idx = m_sel ? cur_lvl : 2'd0;
        if (sp_wr_en) m_sp[idx] = sp_wr_data;
        if (exc_take) begin
            m_sav[exc_dst_lvl] = m_sel;
            m_sel = 1'b1;
        end else if (exc_ret) begin
            m_sel = m_sav[cur_lvl];
        end else if (sel_wr_en && cur_lvl != 2'd0) begin
            m_sel = sel_wr_data[0];
        end
        @(posedge clk);
        #1;
        sel_wr_en = 1'b0; sp_wr_en = 1'b0; exc_take = 1'b0; exc_ret = 1'b0;
    endtask

    task automatic set_lvl(input logic [1:0] l);
        cur_lvl = l;
        #1;
    endtask

    task automatic exp_sp(input string req);
        chk(req, sp_rd, m_sp[m_sel ? cur_lvl : 2'd0]);
    endtask

    task automatic wr_sel(input logic [63:0] d);
        sel_wr_en = 1'b1; sel_wr_data = d;
        step();
    endtask

    task automatic wr_sp(input logic [63:0] d);
        sp_wr_en = 1'b1; sp_wr_data = d;
        step();
    endtask

    task automatic t_reset();
        chk("R6 sel reset", sel_rd, 64'd1);
        for (int l = 0; l < 4; l++) begin
            set_lvl(l[1:0]);
            chk("R6 sp reset", sp_rd, 64'd0);
        end
    endtask

    task automatic t_banked();
        for (int l = 0; l < 4; l++) begin
            set_lvl(l[1:0]);
            wr_sp(64'hA5A5_0000_0000_1000 + 64'(l));
        end
        for (int l = 3; l >= 0; l--) begin
            set_lvl(l[1:0]);
            chk("R4 own pointer", sp_rd, 64'hA5A5_0000_0000_1000 + 64'(l));
        end
        set_lvl(2'd1);
        exp_sp("R13 comb read");
    endtask

    task automatic t_shared();
        set_lvl(2'd2);
        wr_sel(64'd0);
        chk("R12 sel write at lvl2", sel_rd, 64'd0);
        for (int l = 1; l < 4; l++) begin
            set_lvl(l[1:0]);
            chk("R3 shared pointer", sp_rd, 64'hA5A5_0000_0000_1000);
        end
        wr_sp(64'h1234_5678_9ABC_DEF0);
        chk("R11 write to shared", sp_rd, 64'h1234_5678_9ABC_DEF0);
        wr_sel(64'd1);
        chk("R11 own lvl3 untouched", sp_rd, 64'hA5A5_0000_0000_1003);
        set_lvl(2'd0);
        chk("R1 lvl0 holds write", sp_rd, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_el0();
        set_lvl(2'd0);
        chk("R5 lvl0 with sel=1", sp_rd, m_sp[0]);
        wr_sel(64'd0);
        chk("R12 ignored at lvl0", sel_rd, 64'd1);
        set_lvl(2'd1);
        exp_sp("R4 after ignored write");
    endtask

    task automatic t_reserved();
        set_lvl(2'd1);
        wr_sel(~64'd1);
        chk("R2 upper bits dropped", sel_rd, 64'd0);
        wr_sel(~64'd0);
        chk("R2 bit0 only", sel_rd, 64'd1);
    endtask

    task automatic t_vec();
        set_lvl(2'd1);
        exc_take = 1'b1; exc_src_lvl = 2'd1; exc_dst_lvl = 2'd1; #1;
        chk("R7 same lvl own", {62'd0, vec_grp}, 64'd1);
        step();
        set_lvl(2'd2);
        wr_sel(64'd0);
        exc_take = 1'b1; exc_src_lvl = 2'd2; exc_dst_lvl = 2'd2; #1;
        chk("R7 same lvl shared", {62'd0, vec_grp}, 64'd0);
        step();
        wr_sel(64'd0);
        exc_take = 1'b1; exc_src_lvl = 2'd0; exc_dst_lvl = 2'd2; #1;
        chk("R8 lower with sel=0", {62'd0, vec_grp}, 64'd2);
        step();
        exc_take = 1'b1; exc_src_lvl = 2'd1; exc_dst_lvl = 2'd3; #1;
        chk("R8 lower with sel=1", {62'd0, vec_grp}, 64'd2);
        step();
    endtask

    task automatic t_entry_ret();
        set_lvl(2'd1);
        wr_sel(64'd0);
        exc_take = 1'b1; exc_src_lvl = 2'd1; exc_dst_lvl = 2'd1;
        step();
        chk("R9 entry sets sel", sel_rd, 64'd1);
        exp_sp("R4 after entry");
        exc_ret = 1'b1;
        step();
        chk("R10 return restores 0", sel_rd, 64'd0);
        exp_sp("R3 after return");
        exc_take = 1'b1; exc_src_lvl = 2'd1; exc_dst_lvl = 2'd2;
        step();
        set_lvl(2'd2);
        wr_sel(64'd1);
        exc_ret = 1'b1;
        step();
        chk("R10 return restores saved 0", sel_rd, {63'd0, m_sel});
        chk("R10 model value", {63'd0, m_sel}, 64'd0);
        exc_take = 1'b1; exc_src_lvl = 2'd2; exc_dst_lvl = 2'd2;
        sel_wr_en = 1'b1; sel_wr_data = 64'd0;
        step();
        chk("R12 entry beats sel write", sel_rd, 64'd1);
        exc_ret = 1'b1; sel_wr_en = 1'b1; sel_wr_data = 64'd1;
        step();
        chk("R12 return beats sel write", sel_rd, 64'd0);
    endtask

    initial begin
        for (int l = 0; l < 4; l++) m_sp[l] = '0;
        m_sel = 1'b1;
        m_sav = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_banked();
        t_shared();
        t_el0();
        t_reserved();
        t_vec();
        t_entry_ret();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule